// File: doc/BRIEF.md
# Memory tag check unit

This unit sits beside a load/store pipeline and enforces 4-bit version tags on memory. The modelled physical memory is split into 64-byte blocks. A small tag RAM keeps one tag for each block, indexed by physical address bits above bit 5. Each request carries a virtual address whose top four bits hold the tag that the requester expects. It also carries the translation attributes of the page, the processor-state word and an address-space identifier. Requests with one of two tag-store identifiers write the tag RAM. All other requests are checked against it when both the page enable and the thread enable are set.

A mismatch blocks the access. A one-bit mode input picks how the fault is reported. In precise mode the fault is returned with the response of that access. In deferred mode the response shows neither completion nor fault, and the faulting address and code are latched in a sticky status register until an acknowledge clears it. A separate combinational path removes the tag from DMA addresses.

Requests use a valid/ready handshake with a one-entry response register. A request is taken on any edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the response register is empty, or when its content is leaving in the same cycle. The response appears one cycle after the request is taken. It stays unchanged while `rsp_ready` is low.

Top module: `mtag_check_unit`

## Requirements
- R1: After reset `rsp_valid`, `dfr_valid` are 0, `req_ready` is 1 and every stored tag is 0, so a checked access with expected tag 0 completes.
- R2: A request with identifier 0x90 or 0x92 whose page attribute bit 9 is 1 writes `req_wtag` into the entry of block `req_paddr>>6` and completes (done=1, fault=0, code 0); no other entry changes, and later accesses see the new tag.
- R3: An access with attribute bit 9 = 1, processor-state bit 11 = 1 and `req_vaddr[63:60]` equal to the stored tag completes with done=1, fault=0, code 0.
- R4: A checked access with differing tags while `precise_mode`=1 responds with fault=1, done=0, code 17, and leaves the deferred status unchanged.
- R5: A checked mismatch while `precise_mode`=0 responds with done=0, fault=0, code 0. In the same edge that takes the request, `dfr_valid` is set and `dfr_addr`, `dfr_code` take the virtual address and code 17.
- R6: When attribute bit 9 or processor-state bit 11 is 0, an ordinary access completes whatever its tag bits hold.
- R7: A tag-store request whose attribute bit 9 is 0 responds with fault=1, done=0, code 18, and does not write the tag RAM.
- R8: The deferred status holds its first fault while `dfr_valid` is 1. Later deferred faults do not overwrite it, and a one-cycle `dfr_ack` clears `dfr_valid`.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response outputs keep their values.
- R10: `dma_out_addr` equals `dma_in_addr` with bits 63:60 replaced by copies of bit 59, in the same cycle.
- R11: A response never shows done and fault together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| precise_mode | input | 1 | 1: mismatch faults precise; 0: deferred |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_vaddr | input | 64 | Virtual address; bits 63:60 expected tag |
| req_paddr | input | PA_W | Physical address; block index from bit 6 up |
| req_asi | input | 8 | Address-space identifier; 0x90/0x92 tag store |
| req_pte | input | 12 | Page attributes; bit 9 page check enable |
| req_pstate | input | 12 | Processor state; bit 11 thread check enable |
| req_wtag | input | 4 | Tag value for tag stores |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_done | output | 1 | Access completed normally |
| rsp_fault | output | 1 | Precise fault |
| rsp_code | output | 5 | Fault code: 17 mismatch, 18 checking disabled |
| dfr_valid | output | 1 | Sticky deferred fault pending |
| dfr_addr | output | 64 | Virtual address of the deferred fault |
| dfr_code | output | 5 | Code of the deferred fault |
| dfr_ack | input | 1 | Clears the deferred status |
| dma_in_addr | input | 64 | Tagged DMA address |
| dma_out_addr | output | 64 | DMA address with tag replaced by bit-59 sign |

## Verification
Accesses are tried with matching tags, with differing tags in both reporting modes, and with each of the two enables cleared on its own. Together these show that a comparison happens only when both enables are set. Tag stores through both identifiers, followed by reads of the written block and of a neighbouring block, show that the write hit the right entry and only that one. Tag stores to a disabled page show code 18 and an unchanged entry. A stalled response, back-to-back deferred faults with an acknowledge, and DMA addresses with bit 59 at both values cover the handshake, the stickiness of the status and the address cleaning.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  localparam int VA_W    = 64;
  localparam int TAG_W   = 4;
  localparam int ASI_W   = 8;
  localparam int ATTR_W  = 12;
  localparam int CODE_W  = 5;
  localparam int BLK_SH  = 6;
  localparam int PTE_CHK_BIT = 9;
  localparam int PST_CHK_BIT = 11;

  localparam logic [ASI_W-1:0]  ASI_TAG_PLAIN = 8'h90;
  localparam logic [ASI_W-1:0]  ASI_TAG_BLKI  = 8'h92;
  localparam logic [CODE_W-1:0] CODE_NONE     = 5'd0;
  localparam logic [CODE_W-1:0] CODE_MISMATCH = 5'd17;
  localparam logic [CODE_W-1:0] CODE_DISABLED = 5'd18;

  typedef struct packed {
    logic              done;
    logic              fault;
    logic [CODE_W-1:0] code;
  } verdict_t;
endpackage

// File: rtl/mtag_store.sv
module mtag_store
  import mtag_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        mem_q[e] <= wr_tag;
      end
    end
  end

  // Read returns the stored value before any write on this edge.
  assign rd_tag = mem_q[rd_idx];
endmodule

// File: rtl/mtag_judge.sv
module mtag_judge
  import mtag_pkg::*;
(
  input  logic             is_tag_store,
  input  logic             page_en,
  input  logic             thread_en,
  input  logic             precise,
  input  logic [TAG_W-1:0] va_tag,
  input  logic [TAG_W-1:0] mem_tag,
  output logic             wr_tag,
  output logic             defer,
  output verdict_t         verdict
);
  logic checked;
  logic differ;

  assign checked = page_en && thread_en;
  assign differ  = (va_tag != mem_tag);

  always_comb begin
    wr_tag  = 1'b0;
    defer   = 1'b0;
    verdict = '{done: 1'b1, fault: 1'b0, code: CODE_NONE};
    if (is_tag_store) begin
      if (page_en) begin
        wr_tag = 1'b1;
      end else begin
        verdict = '{done: 1'b0, fault: 1'b1, code: CODE_DISABLED};
      end
    end else if (checked && differ) begin
      if (precise) begin
        verdict = '{done: 1'b0, fault: 1'b1, code: CODE_MISMATCH};
      end else begin
        verdict = '{done: 1'b0, fault: 1'b0, code: CODE_NONE};
        defer   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtag_defer_stat.sv
module mtag_defer_stat
  import mtag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [VA_W-1:0]   set_addr,
  input  logic [CODE_W-1:0] set_code,
  input  logic              ack,
  output logic              valid,
  output logic [VA_W-1:0]   addr,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      code  <= CODE_NONE;
    end else begin
      if (ack) valid <= 1'b0;
      if (set && (!valid || ack)) begin
        valid <= 1'b1;
        addr  <= set_addr;
        code  <= set_code;
      end
    end
  end

  AST_DFR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(addr) && $stable(code))); // R8
endmodule

// File: rtl/mtag_dma_clean.sv
module mtag_dma_clean
  import mtag_pkg::*;
(
  input  logic [VA_W-1:0] addr_in,
  output logic [VA_W-1:0] addr_out
);
  localparam int SIGN_BIT = VA_W - TAG_W - 1;

  for (genvar b = 0; b < TAG_W; b++) begin : g_sign
    assign addr_out[VA_W-1-b] = addr_in[SIGN_BIT];
  end
  assign addr_out[SIGN_BIT:0] = addr_in[SIGN_BIT:0];
endmodule

// File: rtl/mtag_check_unit.sv
module mtag_check_unit
  import mtag_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              precise_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic [PA_W-1:0]   req_paddr,
  input  logic [7:0]        req_asi,
  input  logic [11:0]       req_pte,
  input  logic [11:0]       req_pstate,
  input  logic [3:0]        req_wtag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [4:0]        rsp_code,
  output logic              dfr_valid,
  output logic [63:0]       dfr_addr,
  output logic [4:0]        dfr_code,
  input  logic              dfr_ack,
  input  logic [63:0]       dma_in_addr,
  output logic [63:0]       dma_out_addr
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             accept;
  logic [IDX_W-1:0] blk_idx;
  logic [TAG_W-1:0] stored_tag;
  logic             is_tag_store;
  logic             want_wr;
  logic             want_defer;
  verdict_t         verdict;
  verdict_t         rsp_q;
  logic             unused_bits;

  assign unused_bits = ^{req_pte, req_pstate, req_paddr};

  assign req_ready    = !rsp_valid || rsp_ready;
  assign accept       = req_valid && req_ready;
  assign blk_idx      = req_paddr[BLK_SH +: IDX_W];
  assign is_tag_store = (req_asi == ASI_TAG_PLAIN) || (req_asi == ASI_TAG_BLKI);

  mtag_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (blk_idx),
    .rd_tag (stored_tag),
    .wr_en  (accept && want_wr),
    .wr_idx (blk_idx),
    .wr_tag (req_wtag)
  );

  mtag_judge u_judge (
    .is_tag_store (is_tag_store),
    .page_en      (req_pte[PTE_CHK_BIT]),
    .thread_en    (req_pstate[PST_CHK_BIT]),
    .precise      (precise_mode),
    .va_tag       (req_vaddr[VA_W-1 -: TAG_W]),
    .mem_tag      (stored_tag),
    .wr_tag       (want_wr),
    .defer        (want_defer),
    .verdict      (verdict)
  );

  mtag_defer_stat u_dfr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (accept && want_defer),
    .set_addr (req_vaddr),
    .set_code (CODE_MISMATCH),
    .ack      (dfr_ack),
    .valid    (dfr_valid),
    .addr     (dfr_addr),
    .code     (dfr_code)
  );

  mtag_dma_clean u_dma (
    .addr_in  (dma_in_addr),
    .addr_out (dma_out_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_q     <= verdict;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_done  = rsp_q.done;
  assign rsp_fault = rsp_q.fault;
  assign rsp_code  = rsp_q.code;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_done) && $stable(rsp_fault) && $stable(rsp_code))); // R9
  AST_DONE_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_done && rsp_fault)); // R11
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> ((rsp_code == CODE_MISMATCH) || (rsp_code == CODE_DISABLED))); // R4
  AST_DFR_DEFERRED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dfr_valid) |-> !$past(precise_mode)); // R5
endmodule

// File: tb/mtag_check_unit_tb.sv
module mtag_check_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        precise_mode = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [39:0] req_paddr = '0;
  logic [7:0]  req_asi = '0;
  logic [11:0] req_pte = '0;
  logic [11:0] req_pstate = '0;
  logic [3:0]  req_wtag = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_done, rsp_fault;
  logic [4:0]  rsp_code;
  logic        dfr_valid;
  logic [63:0] dfr_addr;
  logic [4:0]  dfr_code;
  logic        dfr_ack = 1'b0;
  logic [63:0] dma_in_addr = '0;
  logic [63:0] dma_out_addr;

  mtag_check_unit u_dut (.*);

  typedef struct {
    logic       d;
    logic       f;
    logic [4:0] c;
    string      r;
  } exp_t;

  exp_t       sb[$];
  logic [3:0] model_tag [64];
  int checks = 0;
  int failures = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: pushes the expected verdict when the request is taken.
  task automatic send(input logic [3:0] vtag, input int blk, input logic [7:0] asi,
                      input logic mcd, input logic pen, input logic [3:0] wtag, input string req);
    exp_t e;
    logic ts;
    @(negedge clk);
    req_vaddr  = {vtag, 60'h0000_1000_0000_000} | (64'(blk) << 6);
    req_paddr  = 40'(blk) << 6 | 40'h15;
    req_asi    = asi;
    req_pte    = {2'b0, mcd, 9'h0};
    req_pstate = {pen, 11'h0};
    req_wtag   = wtag;
    req_valid  = 1'b1;
    ts = (asi == 8'h90) || (asi == 8'h92);
    e.r = req;
    if (ts) begin
      if (mcd) begin e.d = 1; e.f = 0; e.c = 0; model_tag[blk] = wtag; end
      else begin e.d = 0; e.f = 1; e.c = 18; end
    end else if (mcd && pen && vtag != model_tag[blk]) begin
      if (precise_mode) begin e.d = 0; e.f = 1; e.c = 17; end
      else begin e.d = 0; e.f = 0; e.c = 0; end
    end else begin
      e.d = 1; e.f = 0; e.c = 0;
    end
    while (!req_ready) @(negedge clk);
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each response as it leaves the design.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({rsp_done, rsp_fault, rsp_code} == {e.d, e.f, e.c}, e.r,
            64'({rsp_done, rsp_fault, rsp_code}), 64'({e.d, e.f, e.c}));
        chk(!(rsp_done && rsp_fault), "R11 done with fault", 64'({rsp_done, rsp_fault}), 64'h2);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] first_va;
    logic        held_done;
    for (int i = 0; i < 64; i++) model_tag[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(dfr_valid == 0, "R1 dfr_valid after reset", 64'(dfr_valid), 0);
    chk(req_ready == 1, "R1 req_ready after reset", 64'(req_ready), 1);
    send(4'h0, 3, 8'h00, 1, 1, 4'h0, "R1 reset tag zero");

    send(4'h0, 3, 8'h90, 1, 1, 4'h5, "R2 plain tag store");
    send(4'h5, 3, 8'h00, 1, 1, 4'h0, "R3 matching tag");
    send(4'h6, 3, 8'h00, 1, 1, 4'h0, "R4 precise mismatch");
    chk(dfr_valid == 0, "R4 no deferred status", 64'(dfr_valid), 0);
    send(4'h0, 4, 8'h00, 1, 1, 4'h0, "R2 neighbour untouched");
    send(4'h0, 10, 8'h92, 1, 1, 4'hA, "R2 block-init tag store");
    send(4'hA, 10, 8'h00, 1, 1, 4'h0, "R2 block-init tag visible");

    send(4'h7, 3, 8'h00, 0, 1, 4'h0, "R6 page enable clear");
    send(4'h7, 3, 8'h00, 1, 0, 4'h0, "R6 thread enable clear");

    send(4'h0, 3, 8'h90, 0, 1, 4'h9, "R7 tag store disabled page");
    send(4'h5, 3, 8'h00, 1, 1, 4'h0, "R7 tag unchanged");

    precise_mode = 1'b0;
    send(4'h1, 3, 8'h00, 1, 1, 4'h0, "R5 deferred response");
    first_va = {4'h1, 60'h0000_1000_0000_000} | (64'd3 << 6);
    chk(dfr_valid == 1, "R5 dfr_valid set", 64'(dfr_valid), 1);
    chk(dfr_addr == first_va, "R5 dfr_addr", dfr_addr, first_va);
    chk(dfr_code == 5'd17, "R5 dfr_code", 64'(dfr_code), 17);
    send(4'h2, 10, 8'h00, 1, 1, 4'h0, "R8 second deferred response");
    chk(dfr_addr == first_va, "R8 first fault kept", dfr_addr, first_va);
    dfr_ack = 1'b1;
    @(negedge clk);
    dfr_ack = 1'b0;
    chk(dfr_valid == 0, "R8 ack clears", 64'(dfr_valid), 0);
    precise_mode = 1'b1;
    send(4'h3, 10, 8'h00, 1, 1, 4'h0, "R4 precise after ack");
    chk(dfr_valid == 0, "R4 precise leaves status clear", 64'(dfr_valid), 0);

    repeat (2) @(negedge clk);
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(4'h4, 3, 8'h00, 1, 1, 4'h0, "R9 stalled response");
    held_done = rsp_done;
    chk(rsp_valid == 1, "R9 response valid", 64'(rsp_valid), 1);
    chk(req_ready == 0, "R9 ready low on stall", 64'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1 && rsp_done == held_done, "R9 response held", 64'({rsp_valid, rsp_done}), 64'({1'b1, held_done}));
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(rsp_valid == 0, "R9 response drained", 64'(rsp_valid), 0);

    dma_in_addr = 64'hA800_0000_1234_5678; #1;
    chk(dma_out_addr == 64'hF800_0000_1234_5678, "R10 bit59 one", dma_out_addr, 64'hF800_0000_1234_5678);
    dma_in_addr = 64'h5700_00AB_CDEF_0040; #1;
    chk(dma_out_addr == 64'h0700_00AB_CDEF_0040, "R10 bit59 zero", dma_out_addr, 64'h0700_00AB_CDEF_0040);
    dma_in_addr = 64'h0F00_0000_0000_0001; #1;
    chk(dma_out_addr == 64'hFF00_0000_0000_0001, "R10 untagged negative", dma_out_addr, 64'hFF00_0000_0000_0001);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R9 scoreboard drained", 64'(sb.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule